// File: doc/BRIEF.md
# ATA PIO Cycle Timing Sequencer

This block runs one parallel-ATA programmed-I/O transfer at a time, either a register access or a data-word access. A host presents a request with a direction, a three-bit register address, two active-low chip-select values and a 16-bit write word. The sequencer then places the address and chip selects on the cable and waits a setup time. It pulses the read or write strobe low and, when the transfer ends, observes a recovery gap. It reports completion with a one-clock pulse. All durations are clock counts taken from configuration inputs. A PIO mode input sets how long write data stays driven after the write strobe rises.

The strobe can be stretched by the device's ready line. That line passes through a two-stage synchronizer. The synchronizer latency is part of the earliest point at which it is looked at. A stretch is bounded by a total strobe limit, and reaching that limit raises a sticky timeout flag while the transfer still completes. The recovery gap is whichever is longer: the minimum recovery count, or the part of the total cycle count left after the strobe. For writes, the gap is never shorter than the hold time.

The controller has five states. IDLE goes to SETUP when a request arrives. SETUP goes to STROBE when its count ends. STROBE goes to RECOVER when the strobe count ends and the ready line is high or ignored. STROBE goes to STRETCH when the ready line is low. STRETCH goes to RECOVER when ready rises or the strobe limit is reached. RECOVER goes to IDLE with the done pulse.

Top module: `pio_cycle_seq`

## Requirements
- R1: After reset both strobes are high, both chip selects are high (3), the data output enable is low, `req_ready` is high, and `done` and `iordy_timeout` are low.
- R2: A request is taken only while `req_ready` is high (IDLE). While a transfer runs, `req_ready` stays low, and any request presented at that time leaves the driven address and chip selects unchanged.
- R3: Once a request is accepted, the address and chip selects are driven with both strobes high for max(`cfg_setup`,1) clocks before a strobe falls.
- R4: The strobe for the requested direction (write: `ata_diow_n`, read: `ata_dior_n`) is low for max(`cfg_active`,1) clocks while IORDY handling is off or the ready line is high, and the other strobe stays high. Both strobes are never low together.
- R5: During a write, `ata_dd_oe` is high and `ata_dd_out` carries the request's write word for every clock that `ata_diow_n` is low.
- R6: After `ata_diow_n` rises, `ata_dd_oe` stays high for 3 clocks in PIO mode 0, 2 clocks in modes 1 and 2, and 1 clock in modes 3 and above. It is low after a read.
- R7: On a read, `rd_data` takes the value of `ata_dd_in` at the clock edge where `ata_dior_n` rises, and keeps it until the next read, including across writes.
- R8: The recovery gap after the strobe rises lasts R clocks. R is `cfg_cycle` − S when `cfg_cycle` > S and that difference exceeds `cfg_recover`; otherwise it is `cfg_recover`. Here S is the number of strobe-low clocks. R is at least 1 clock, and for a write at least the R6 hold count.
- R9: `done` is high for exactly one clock, the last clock of the recovery gap. `req_ready` is high on the following clock.
- R10: With `cfg_iordy_en` high, the strobe is low for at least 4 clocks (2 clocks of minimum sampling delay plus 2 synchronizer stages). If the synchronized ready line is low when the strobe count ends, the strobe stays low until it is seen high.
- R11: A stretched strobe ends after 64 strobe-low clocks in total. In that case `iordy_timeout` is set, the transfer completes through recovery and `done`, and the flag stays set until reset.
- R12: With `cfg_iordy_en` low, `ata_iordy` has no effect on the strobe width or on `iordy_timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | High while idle; a request is taken when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Device register address |
| req_cs_n | input | 2 | Active-low chip-select values for the transfer |
| req_wdata | input | 16 | Write word |
| cfg_setup | input | 8 | Setup clocks before the strobe |
| cfg_active | input | 8 | Strobe-low clocks |
| cfg_recover | input | 8 | Minimum recovery clocks |
| cfg_cycle | input | 8 | Total strobe-plus-recovery clocks |
| cfg_iordy_en | input | 1 | Enables ready-line stretching |
| cfg_pio_mode | input | 3 | PIO mode, selects write hold time |
| ata_addr | output | 3 | Address lines to the device |
| ata_cs_n | output | 2 | Chip selects to the device |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | 16 | Data bus outbound value |
| ata_dd_oe | output | 1 | Data bus output enable |
| ata_dd_in | input | 16 | Data bus inbound value |
| ata_iordy | input | 1 | Device ready line, asynchronous |
| rd_data | output | 16 | Last word read |
| done | output | 1 | One-clock completion pulse |
| iordy_timeout | output | 1 | Sticky ready-line timeout flag |

## Verification
The bench samples at every falling clock edge from the clock after acceptance. It classifies each sample as setup, strobe or recovery from the chip selects and strobes, and counts clocks per phase. Every count is compared with the R3, R4, R8 and R6 formulas evaluated by the bench from the vector's configuration. `done` is due on the last recovery sample and `req_ready` on the sample after it. `rd_data` is due at the edge where the read strobe rises, so it is checked once the transfer has ended, after `ata_dd_in` has been changed. For ready-line tests the strobe width is checked against a bound, because the release reaches the controller only after the two synchronizer stages.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_STRETCH,
        ST_RECOVER
    } pio_state_e;
endpackage

// File: rtl/pio_iordy_sync.sv
module pio_iordy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pio_hold_sel.sv
module pio_hold_sel #(
    parameter int MODE_W = 3,
    parameter int HOLD_W = 2
) (
    input  logic [MODE_W-1:0] pio_mode,
    output logic [HOLD_W-1:0] hold_clks
);
    always_comb begin
        unique case (pio_mode)
            MODE_W'(0):            hold_clks = HOLD_W'(3);
            MODE_W'(1), MODE_W'(2): hold_clks = HOLD_W'(2);
            default:               hold_clks = HOLD_W'(1);
        endcase
    end
endmodule

// File: rtl/pio_recover_calc.sv
module pio_recover_calc #(
    parameter int W      = 9,
    parameter int HOLD_W = 2
) (
    input  logic [W-1:0]      cycle_len,
    input  logic [W-1:0]      recover_min,
    input  logic [W-1:0]      spent,
    input  logic              is_write,
    input  logic [HOLD_W-1:0] hold_clks,
    output logic [W-1:0]      gap_len
);
    logic [W-1:0] remain;
    logic [W-1:0] base;

    always_comb begin
        remain = cycle_len - spent;
        if ((cycle_len > spent) && (remain > recover_min)) base = remain;
        else                                               base = recover_min;
        if (base == '0) base = W'(1);
        if (is_write && (base < W'(hold_clks))) base = W'(hold_clks);
        gap_len = base;
    end
endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
    import pio_seq_pkg::*;
#(
    parameter int CNT_W            = 8,
    parameter int DATA_W           = 16,
    parameter int ADDR_W           = 3,
    parameter int CS_W             = 2,
    parameter int MODE_W           = 3,
    parameter int SYNC_STAGES      = 2,
    parameter int IORDY_FIRST_CLKS = 2,
    parameter int IORDY_MAX_CLKS   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CS_W-1:0]   req_cs_n,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_active,
    input  logic [CNT_W-1:0]  cfg_recover,
    input  logic [CNT_W-1:0]  cfg_cycle,
    input  logic              cfg_iordy_en,
    input  logic [MODE_W-1:0] cfg_pio_mode,
    output logic [ADDR_W-1:0] ata_addr,
    output logic [CS_W-1:0]   ata_cs_n,
    output logic              ata_dior_n,
    output logic              ata_diow_n,
    output logic [DATA_W-1:0] ata_dd_out,
    output logic              ata_dd_oe,
    input  logic [DATA_W-1:0] ata_dd_in,
    input  logic              ata_iordy,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              iordy_timeout
);
    localparam int W           = CNT_W + 1;
    localparam int HOLD_W      = 2;
    localparam int SAMPLE_CLKS = IORDY_FIRST_CLKS + SYNC_STAGES;
    localparam logic [W-1:0] SAMPLE_LEN = W'(SAMPLE_CLKS);
    localparam logic [W-1:0] MAX_LEN    = W'(IORDY_MAX_CLKS);

    pio_state_e        state, state_nx;
    logic [W-1:0]      cnt, act, gap_q;
    logic              lat_write;
    logic [ADDR_W-1:0] lat_addr;
    logic [CS_W-1:0]   lat_cs;
    logic [DATA_W-1:0] lat_wdata;
    logic              iordy_s;
    logic [HOLD_W-1:0] hold_clks;
    logic [W-1:0]      setup_len, strobe_len, spent, gap_len;
    logic              strobing;

    pio_iordy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(ata_iordy), .q_sync(iordy_s)
    );

    pio_hold_sel #(.MODE_W(MODE_W), .HOLD_W(HOLD_W)) u_hold (
        .pio_mode(cfg_pio_mode), .hold_clks(hold_clks)
    );

    pio_recover_calc #(.W(W), .HOLD_W(HOLD_W)) u_gap (
        .cycle_len(W'(cfg_cycle)), .recover_min(W'(cfg_recover)), .spent(spent),
        .is_write(lat_write), .hold_clks(hold_clks), .gap_len(gap_len)
    );

    // Derived lengths
    always_comb begin
        setup_len  = (cfg_setup == '0) ? W'(1) : W'(cfg_setup);
        strobe_len = (cfg_active == '0) ? W'(1) : W'(cfg_active);
        if (cfg_iordy_en && (strobe_len < SAMPLE_LEN)) strobe_len = SAMPLE_LEN;
        spent = act + W'(1);
    end

    // Next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req_valid) state_nx = ST_SETUP;
            ST_SETUP:   if (cnt + W'(1) >= setup_len) state_nx = ST_STROBE;
            ST_STROBE:  if (spent >= strobe_len) begin
                            if (cfg_iordy_en && !iordy_s && (spent < MAX_LEN)) state_nx = ST_STRETCH;
                            else                                               state_nx = ST_RECOVER;
                        end
            ST_STRETCH: if (iordy_s || (spent >= MAX_LEN)) state_nx = ST_RECOVER;
            ST_RECOVER: if (cnt + W'(1) >= gap_q) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            cnt           <= '0;
            act           <= '0;
            gap_q         <= W'(1);
            lat_write     <= 1'b0;
            lat_addr      <= '0;
            lat_cs        <= '1;
            lat_wdata     <= '0;
            rd_data       <= '0;
            iordy_timeout <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && req_valid) begin
                lat_write <= req_write;
                lat_addr  <= req_addr;
                lat_cs    <= req_cs_n;
                lat_wdata <= req_wdata;
            end
            if (state_nx != state) cnt <= '0;
            else                   cnt <= cnt + W'(1);
            if (state == ST_SETUP)                          act <= '0;
            else if (state == ST_STROBE || state == ST_STRETCH) act <= spent;
            if ((state == ST_STROBE || state == ST_STRETCH) && state_nx == ST_RECOVER) begin
                gap_q <= gap_len;
                if (!lat_write) rd_data <= ata_dd_in;
                if (cfg_iordy_en && !iordy_s && spent >= MAX_LEN) iordy_timeout <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        strobing   = (state == ST_STROBE) || (state == ST_STRETCH);
        req_ready  = (state == ST_IDLE);
        ata_addr   = lat_addr;
        ata_cs_n   = (state == ST_IDLE) ? '1 : lat_cs;
        ata_dior_n = !(strobing && !lat_write);
        ata_diow_n = !(strobing && lat_write);
        ata_dd_out = lat_wdata;
        ata_dd_oe  = lat_write && (strobing || (state == ST_RECOVER && cnt < W'(hold_clks)));
        done       = (state == ST_RECOVER) && (cnt + W'(1) >= gap_q);
    end

    // R1
    idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ata_cs_n == '1) |-> (ata_dior_n && ata_diow_n));
    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R4
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ata_dior_n && !ata_diow_n));
    // R5
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ata_diow_n |-> ata_dd_oe);
    // R6
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ata_diow_n) |-> ata_dd_oe);
    // R7
    read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ata_dior_n) |-> (rd_data == $past(ata_dd_in)));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));
    // R11
    timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iordy_timeout |=> iordy_timeout);
endmodule

// File: tb/pio_cycle_seq_tb.sv
module pio_cycle_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [2:0]  req_addr = '0;
    logic [1:0]  req_cs_n = 2'b11;
    logic [15:0] req_wdata = '0;
    logic [7:0]  cfg_setup = 8'd1, cfg_active = 8'd1, cfg_recover = 8'd1, cfg_cycle = 8'd0;
    logic        cfg_iordy_en = 1'b0;
    logic [2:0]  cfg_pio_mode = '0;
    logic [2:0]  ata_addr;
    logic [1:0]  ata_cs_n;
    logic        ata_dior_n, ata_diow_n, ata_dd_oe;
    logic [15:0] ata_dd_out, rd_data;
    logic [15:0] ata_dd_in = '0;
    logic        ata_iordy = 1'b1;
    logic        done, iordy_timeout;

    int n_checks = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    pio_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_cs_n(req_cs_n), .req_wdata(req_wdata),
        .cfg_setup(cfg_setup), .cfg_active(cfg_active), .cfg_recover(cfg_recover),
        .cfg_cycle(cfg_cycle), .cfg_iordy_en(cfg_iordy_en), .cfg_pio_mode(cfg_pio_mode),
        .ata_addr(ata_addr), .ata_cs_n(ata_cs_n), .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
        .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe), .ata_dd_in(ata_dd_in), .ata_iordy(ata_iordy),
        .rd_data(rd_data), .done(done), .iordy_timeout(iordy_timeout)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  a;
        logic [1:0]  cs;
        logic [15:0] wd;
        logic [15:0] rd;
        logic [7:0]  s;
        logic [7:0]  act;
        logic [7:0]  rec;
        logic [7:0]  cyc;
        logic [2:0]  mode;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 2'b10, 16'hA5C3, 16'h0000, 8'd2, 8'd3, 8'd2, 8'd10, 3'd0},
        '{1'b0, 3'd7, 2'b01, 16'h0000, 16'h1234, 8'd0, 8'd1, 8'd4, 8'd3,  3'd0},
        '{1'b1, 3'd3, 2'b10, 16'hFFFF, 16'h0000, 8'd1, 8'd5, 8'd1, 8'd5,  3'd1},
        '{1'b1, 3'd5, 2'b01, 16'h0F0F, 16'h0000, 8'd4, 8'd2, 8'd0, 8'd0,  3'd3},
        '{1'b0, 3'd2, 2'b10, 16'h0000, 16'hBEEF, 8'd3, 8'd8, 8'd2, 8'd20, 3'd2},
        '{1'b1, 3'd6, 2'b10, 16'h8001, 16'h0000, 8'd1, 8'd0, 8'd3, 8'd6,  3'd4},
        '{1'b0, 3'd1, 2'b01, 16'h0000, 16'h5A5A, 8'd2, 8'd6, 8'd6, 8'd12, 3'd2}
    };

    // per-transfer observations
    int m_setup, m_strobe, m_rec, m_hold, m_done;
    int m_bad_strobe, m_bad_data, m_bad_addr, m_busy_ready;
    bit m_fin;

    task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    function automatic int hold_of(input int mode);
        if (mode == 0) return 3;
        if (mode <= 2) return 2;
        return 1;
    endfunction

    function automatic int gap_of(input int cyc, input int rec, input int spent,
                                  input bit wr, input int mode);
        int g;
        g = (cyc > spent && cyc - spent > rec) ? cyc - spent : rec;
        if (g < 1) g = 1;
        if (wr && g < hold_of(mode)) g = hold_of(mode);
        return g;
    endfunction

    task automatic run_xfer(input bit wr, input logic [2:0] a, input logic [1:0] cs,
                            input logic [15:0] wd, input bit keep_busy);
        int phase;
        m_setup = 0; m_strobe = 0; m_rec = 0; m_hold = 0; m_done = 0;
        m_bad_strobe = 0; m_bad_data = 0; m_bad_addr = 0; m_busy_ready = 0; m_fin = 0;
        phase = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_cs_n = cs; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        if (keep_busy) begin
            req_addr = ~a; req_cs_n = ~cs; req_wdata = ~wd; req_write = ~wr;
        end else begin
            req_valid = 1'b0;
        end
        for (int i = 0; i < 2000; i++) begin
            if (phase == 0 && (!ata_dior_n || !ata_diow_n)) phase = 1;
            if (phase == 1 && ata_dior_n && ata_diow_n) phase = 2;
            if (req_ready) m_busy_ready++;
            if (ata_addr != a || ata_cs_n != cs) m_bad_addr++;
            if (done) m_done++;
            if (phase == 0) m_setup++;
            else if (phase == 1) begin
                m_strobe++;
                if (wr ? (ata_diow_n || !ata_dior_n) : (ata_dior_n || !ata_diow_n)) m_bad_strobe++;
                if (wr && (!ata_dd_oe || ata_dd_out != wd)) m_bad_data++;
            end else begin
                m_rec++;
                if (ata_dd_oe) m_hold++;
                if (done) begin m_fin = 1; break; end
            end
            @(negedge clk);
        end
        if (keep_busy) req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_vec(input vec_t v, input int exp_strobe, inout logic [15:0] exp_rd);
        int es, eg, eh;
        es = (v.s == 0) ? 1 : int'(v.s);
        eg = gap_of(int'(v.cyc), int'(v.rec), exp_strobe, v.wr, int'(v.mode));
        eh = v.wr ? hold_of(int'(v.mode)) : 0;
        chk(m_fin, "R9 transfer completes", m_fin, 1);
        chk(m_setup == es, "R3 setup clocks", m_setup, es);
        chk(m_strobe == exp_strobe, "R4 strobe clocks", m_strobe, exp_strobe);
        chk(m_bad_strobe == 0, "R4 correct strobe only", m_bad_strobe, 0);
        chk(m_bad_addr == 0, "R2 R3 address and chip selects held", m_bad_addr, 0);
        chk(m_bad_data == 0, "R5 write data on bus", m_bad_data, 0);
        chk(m_rec == eg, "R8 recovery clocks", m_rec, eg);
        chk(m_hold == eh, "R6 write hold clocks", m_hold, eh);
        chk(m_done == 1, "R9 single done pulse", m_done, 1);
        chk(req_ready && !done, "R9 ready after done", int'(req_ready), 1);
        if (!v.wr) exp_rd = v.rd;
        ata_dd_in = ~v.rd;
        @(negedge clk);
        chk(rd_data == exp_rd, "R7 read data captured and held", int'(rd_data), int'(exp_rd));
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog all-requirements actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [15:0] exp_rd;
        int ea;
        exp_rd = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ata_dior_n && ata_diow_n, "R1 strobes high in reset", int'({ata_dior_n, ata_diow_n}), 3);
        chk(ata_cs_n == 2'b11 && !ata_dd_oe, "R1 cs high oe low in reset", int'(ata_cs_n), 3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && !iordy_timeout, "R1 idle after reset",
            int'({req_ready, done, iordy_timeout}), 4);

        // vector table
        for (int k = 0; k < NV; k++) begin
            cfg_setup = VECS[k].s; cfg_active = VECS[k].act; cfg_recover = VECS[k].rec;
            cfg_cycle = VECS[k].cyc; cfg_pio_mode = VECS[k].mode; cfg_iordy_en = 1'b0;
            ata_dd_in = VECS[k].rd;
            run_xfer(VECS[k].wr, VECS[k].a, VECS[k].cs, VECS[k].wd, 1'b0);
            ea = (VECS[k].act == 0) ? 1 : int'(VECS[k].act);
            check_vec(VECS[k], ea, exp_rd);
        end

        // R2 request held during busy transfer is not taken
        cfg_setup = 8'd2; cfg_active = 8'd3; cfg_recover = 8'd2; cfg_cycle = 8'd0; cfg_pio_mode = 3'd4;
        run_xfer(1'b1, 3'd4, 2'b10, 16'h1357, 1'b1);
        chk(m_busy_ready == 0, "R2 ready low while busy", m_busy_ready, 0);
        chk(m_bad_addr == 0, "R2 busy request leaves address", m_bad_addr, 0);
        chk(ata_cs_n == 2'b11, "R2 no second transfer started", int'(ata_cs_n), 3);

        // R12 ready line ignored when disabled
        ata_iordy = 1'b0; cfg_iordy_en = 1'b0; cfg_active = 8'd3;
        run_xfer(1'b0, 3'd1, 2'b10, 16'h0, 1'b0);
        chk(m_strobe == 3, "R12 strobe unaffected by iordy", m_strobe, 3);
        chk(!iordy_timeout, "R12 no timeout when disabled", int'(iordy_timeout), 0);

        // R10 minimum sampling width
        ata_iordy = 1'b1; cfg_iordy_en = 1'b1; cfg_active = 8'd2; cfg_setup = 8'd1;
        run_xfer(1'b0, 3'd2, 2'b01, 16'h0, 1'b0);
        chk(m_strobe == 4, "R10 strobe widened to sampling delay", m_strobe, 4);

        // R10 stretch until ready released
        ata_iordy = 1'b0;
        fork
            run_xfer(1'b1, 3'd3, 2'b10, 16'h2468, 1'b0);
            begin repeat (12) @(negedge clk); ata_iordy = 1'b1; end
        join
        chk(m_strobe > 4 && m_strobe < 64, "R10 strobe stretched by iordy", m_strobe, 10);
        chk(m_bad_data == 0, "R5 data held during stretch", m_bad_data, 0);
        chk(!iordy_timeout, "R10 no timeout on release", int'(iordy_timeout), 0);

        // R11 timeout
        ata_iordy = 1'b0; cfg_active = 8'd5; cfg_recover = 8'd2; cfg_cycle = 8'd10;
        run_xfer(1'b0, 3'd0, 2'b10, 16'h0, 1'b0);
        chk(m_strobe == 64, "R11 strobe capped", m_strobe, 64);
        chk(m_fin && m_rec == 2, "R11 recovery after timeout", m_rec, 2);
        chk(iordy_timeout, "R11 timeout flag set", int'(iordy_timeout), 1);
        ata_iordy = 1'b1;
        run_xfer(1'b1, 3'd0, 2'b10, 16'h1111, 1'b0);
        chk(m_fin && iordy_timeout, "R11 timeout flag sticky", int'(iordy_timeout), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule